// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a synchronous host and an asynchronous one-bit-wide dynamic memory with a shared ten-bit address bus. A host request carries a word address, a direction flag, one data bit and a flag that asks for the row to stay open afterwards. The block turns each request into strobe activity on the memory pins:

- a full row cycle, in which RAS falls on the row half of the address and CAS then falls on the column half;
- or a CAS-only cycle, when the requested row is already open.

Writes are always early writes, so the memory never drives its output during a write. Reads return the sampled bit together with a one-cycle completion pulse.

Every analog minimum is given as a nanosecond parameter. It is turned into whole clock cycles by rounding up against the clock-period parameter, and each phase waits on elapsed-cycle counters.

While the host keeps asking for the same row with the keep-open flag set, the row stays active. A different row, a cleared flag, or RAS approaching its page-mode ceiling makes the block raise RAS and wait out the precharge. A different row is then opened automatically for the request that caused the close.

Top module: `dram_page_ctrl`

## Requirements
- R1: The row half of the word address (bits 19:10) is on the address pins when RAS falls. The column half (bits 9:0) is on them when CAS falls.
- R2: CAS falls no sooner than ceil(tRCD/clk) cycles after RAS falls. The row address stays on the pins at least ceil(tRAH/clk) cycles after RAS falls.
- R3: A write drives WE low and the data pin at the CAS falling edge and holds both until CAS rises. CAS stays low at least the largest of the CAS-width, column-hold and data-hold counts. The completion pulse of a write returns data 0.
- R4: A read samples the memory output only once tRAC has elapsed since RAS fell and both tCAC and tAA have elapsed since CAS fell. The sampled bit is returned with the completion pulse.
- R5: RAS stays low at least ceil(tRAS/clk) cycles. It then stays high at least ceil(tRP/clk) cycles, and its falls are at least ceil(tRC/clk) cycles apart.
- R6: A request to the open row, after a request with the keep-open flag, causes only a CAS cycle with no new RAS fall. CAS is high at least ceil(tCP/clk) cycles before that fall, and its falls are at least ceil(tPC/clk) cycles apart.
- R7: A request to a different row while a page is open closes the row, precharges, and opens the new row without the host presenting the request again.
- R8: RAS is never low longer than the page ceiling. An open page with no further requests is closed before it.
- R9: A request is taken only on a cycle with req_valid and req_ready both high. req_ready is low while a strobe cycle or precharge is in progress. Each taken request gives exactly one completion pulse.
- R10: After reset, RAS, CAS and WE are high, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | host request present |
| req_ready | output | 1 | request can be taken this cycle |
| req_addr | input | ROW_W+COL_W | word address, row in the upper half |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DQ_W | write data |
| req_burst | input | 1 | keep the row open after this access |
| rsp_valid | output | 1 | one-cycle completion pulse |
| rsp_rdata | output | DQ_W | read data, 0 for writes |
| dram_a | output | A_W | multiplexed row/column address |
| dram_ras_n | output | 1 | row strobe, active low |
| dram_cas_n | output | 1 | column strobe, active low |
| dram_we_n | output | 1 | write enable, active low |
| dram_di | output | DQ_W | data to the memory |
| dram_do | input | DQ_W | data from the memory |

## Verification
The assertions assume that the host holds a request stable from the cycle it raises req_valid until the cycle it is taken. They also assume that reset lasts long enough for the elapsed counters to start from a known state.

The driver changes its inputs only at the falling clock edge. It keeps every request asserted until a rising edge where req_ready was seen high.

The memory model in the bench measures every strobe interval in nanoseconds against the minimums. It presents an inverted bit until the read access times have all passed, so a read sampled too early returns wrong data.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // RAS high, precharge countdown
    ST_RCD   = 2'd1,  // RAS low, row on the pins
    ST_CASLO = 2'd2,  // CAS low, column on the pins
    ST_CASHI = 2'd3   // RAS low, CAS high, page open
  } seq_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_pg_age.sv
module dram_pg_age #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] age
);
  // Reads as the number of rising edges since the restart edge; saturates.
  always_ff @(posedge clk) begin
    if (rst)                 age <= '0;
    else if (restart)        age <= W'(1);
    else if (age != '1)      age <= age + W'(1);
  end
endmodule

// File: rtl/dram_pg_reqbuf.sv
module dram_pg_reqbuf #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int DQ_W  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic             in_wr,
  input  logic [DQ_W-1:0]  in_wd,
  input  logic             in_keep,
  output logic [ROW_W-1:0] q_row,
  output logic [COL_W-1:0] q_col,
  output logic             q_wr,
  output logic [DQ_W-1:0]  q_wd,
  output logic             q_keep
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_row  <= '0;
      q_col  <= '0;
      q_wr   <= 1'b0;
      q_wd   <= '0;
      q_keep <= 1'b0;
    end else if (load) begin
      q_row  <= in_row;
      q_col  <= in_col;
      q_wr   <= in_wr;
      q_wd   <= in_wd;
      q_keep <= in_keep;
    end
  end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_page_pkg::*;
#(
  parameter int CLK_NS        = 8,
  parameter int ROW_W         = 10,
  parameter int COL_W         = 10,
  parameter int DQ_W          = 1,
  parameter int A_W           = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int T_RAH_NS      = 10,
  parameter int T_RCD_NS      = 20,
  parameter int T_RP_NS       = 40,
  parameter int T_RC_NS       = 110,
  parameter int T_RAS_NS      = 60,
  parameter int T_CAS_NS      = 15,
  parameter int T_CAH_NS      = 15,
  parameter int T_DH_NS       = 15,
  parameter int T_CP_NS       = 10,
  parameter int T_PC_NS       = 40,
  parameter int T_RAC_NS      = 60,
  parameter int T_CAC_NS      = 15,
  parameter int T_AA_NS       = 30,
  parameter int T_RASP_MAX_NS = 100000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_write,
  input  logic [DQ_W-1:0]        req_wdata,
  input  logic                   req_burst,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata,
  output logic [A_W-1:0]         dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DQ_W-1:0]        dram_di,
  input  logic [DQ_W-1:0]        dram_do
);
  // ---- cycle counts, rounded up ----
  localparam int N_RAH   = ns2cyc(T_RAH_NS, CLK_NS);
  localparam int N_RCD   = imax(ns2cyc(T_RCD_NS, CLK_NS), N_RAH);
  localparam int N_RP    = ns2cyc(T_RP_NS, CLK_NS);
  localparam int N_RC    = ns2cyc(T_RC_NS, CLK_NS);
  localparam int N_RAS   = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int N_LOW   = imax(ns2cyc(T_CAS_NS, CLK_NS),
                                imax(ns2cyc(T_CAH_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS)));
  localparam int N_LOR   = imax(N_LOW, imax(ns2cyc(T_CAC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)));
  localparam int N_RAC   = ns2cyc(T_RAC_NS, CLK_NS);
  localparam int N_CP    = ns2cyc(T_CP_NS, CLK_NS);
  localparam int N_PC    = ns2cyc(T_PC_NS, CLK_NS);
  localparam int N_RASP  = T_RASP_MAX_NS / CLK_NS;
  localparam int N_GUARD = N_PC + N_CP + N_RAC + N_LOR + 2;
  localparam int N_LIM   = N_RASP - N_GUARD;
  localparam int AGE_W   = $clog2(N_RASP + 1) + 1;
  localparam int PRE_W   = $clog2(imax(N_RP, N_RC) + 1);

  localparam logic [AGE_W-1:0] A_RCD  = AGE_W'(N_RCD);
  localparam logic [AGE_W-1:0] A_RP   = AGE_W'(N_RP);
  localparam logic [AGE_W-1:0] A_RC   = AGE_W'(N_RC);
  localparam logic [AGE_W-1:0] A_RAS  = AGE_W'(N_RAS);
  localparam logic [AGE_W-1:0] A_LOW  = AGE_W'(N_LOW);
  localparam logic [AGE_W-1:0] A_LOR  = AGE_W'(N_LOR);
  localparam logic [AGE_W-1:0] A_RAC  = AGE_W'(N_RAC);
  localparam logic [AGE_W-1:0] A_CP   = AGE_W'(N_CP);
  localparam logic [AGE_W-1:0] A_PC   = AGE_W'(N_PC);
  localparam logic [AGE_W-1:0] A_LIM  = AGE_W'(N_LIM);
  localparam logic [AGE_W-1:0] A_RASP = AGE_W'(N_RASP);

  seq_state_e          state;
  logic [PRE_W-1:0]    pre_cnt;
  logic                pend;
  logic [AGE_W-1:0]    ras_age, cas_age, hi_age;
  logic [ROW_W-1:0]    q_row;
  logic [COL_W-1:0]    q_col;
  logic                q_wr, q_keep;
  logic [DQ_W-1:0]     q_wd;

  logic [ROW_W-1:0] in_row;
  logic [COL_W-1:0] in_col;
  assign in_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign in_col = req_addr[COL_W-1:0];

  // ---- handshake and phase decisions ----
  logic ready_idle, ready_page, page_room, accept;
  logic start_row, go_cas, lo_done, page_hit, page_miss, close_now;
  logic [ROW_W-1:0] row_src;

  assign page_room  = q_keep && (ras_age < A_LIM);
  assign ready_idle = (state == ST_IDLE) && (pre_cnt == '0) && !pend;
  assign ready_page = (state == ST_CASHI) && page_room && !pend &&
                      (hi_age >= A_CP) && (cas_age >= A_PC);
  assign req_ready  = ready_idle || ready_page;
  assign accept     = req_valid && req_ready;

  assign start_row = (state == ST_IDLE) && (pre_cnt == '0) && (pend || req_valid);
  assign row_src   = pend ? q_row : in_row;
  assign go_cas    = (state == ST_RCD) && (ras_age >= A_RCD);
  assign lo_done   = (state == ST_CASLO) &&
                     (q_wr ? (cas_age >= A_LOW)
                           : ((cas_age >= A_LOR) && (ras_age >= A_RAC)));
  assign page_hit  = accept && (state == ST_CASHI) && (in_row == q_row);
  assign page_miss = accept && (state == ST_CASHI) && (in_row != q_row);
  assign close_now = (state == ST_CASHI) && !page_hit &&
                     (!page_room || pend || page_miss) && (ras_age >= A_RAS);

  // precharge length covers both the RAS-high minimum and the full cycle minimum
  logic [AGE_W-1:0] rc_rem, pre_sel;
  assign rc_rem  = (ras_age >= A_RC) ? '0 : (A_RC - ras_age);
  assign pre_sel = (rc_rem > A_RP) ? rc_rem : A_RP;

  dram_pg_reqbuf #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_reqbuf (
    .clk(clk), .rst(rst), .load(accept),
    .in_row(in_row), .in_col(in_col), .in_wr(req_write), .in_wd(req_wdata),
    .in_keep(req_burst),
    .q_row(q_row), .q_col(q_col), .q_wr(q_wr), .q_wd(q_wd), .q_keep(q_keep)
  );

  dram_pg_age #(.W(AGE_W)) u_ras_age (
    .clk(clk), .rst(rst), .restart(start_row), .age(ras_age));
  dram_pg_age #(.W(AGE_W)) u_cas_age (
    .clk(clk), .rst(rst), .restart(go_cas || page_hit), .age(cas_age));
  dram_pg_age #(.W(AGE_W)) u_hi_age (
    .clk(clk), .rst(rst), .restart(lo_done), .age(hi_age));

  // ---- strobe sequencer, all pin outputs registered ----
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pre_cnt    <= '0;
      pend       <= 1'b0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_a     <= '0;
      dram_di    <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (pre_cnt != '0) pre_cnt <= pre_cnt - PRE_W'(1);
      unique case (state)
        ST_IDLE: if (start_row) begin
          dram_ras_n <= 1'b0;
          dram_a     <= A_W'(row_src);
          pend       <= 1'b0;
          state      <= ST_RCD;
        end
        ST_RCD: if (go_cas) begin
          dram_cas_n <= 1'b0;
          dram_a     <= A_W'(q_col);
          dram_we_n  <= ~q_wr;
          dram_di    <= q_wd;
          state      <= ST_CASLO;
        end
        ST_CASLO: if (lo_done) begin
          dram_cas_n <= 1'b1;
          dram_we_n  <= 1'b1;
          rsp_valid  <= 1'b1;
          rsp_rdata  <= q_wr ? '0 : dram_do;
          state      <= ST_CASHI;
        end
        ST_CASHI: begin
          if (page_miss) pend <= 1'b1;
          if (page_hit) begin
            dram_cas_n <= 1'b0;
            dram_a     <= A_W'(in_col);
            dram_we_n  <= ~req_write;
            dram_di    <= req_wdata;
            state      <= ST_CASLO;
          end else if (close_now) begin
            dram_ras_n <= 1'b1;
            pre_cnt    <= PRE_W'(pre_sel);
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---- protocol checks ----
  assert_ras_to_cas_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) && $past(state) == ST_RCD |-> ras_age >= A_RCD + AGE_W'(1));

  assert_write_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) && !$past(dram_we_n) |-> cas_age > A_LOW);

  assert_we_with_cas_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_we_n) |-> $fell(dram_cas_n));

  assert_read_sample_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) && $past(dram_we_n) |-> cas_age > A_LOR && ras_age > A_RAC);

  assert_done_with_cas_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(dram_cas_n));

  assert_ras_min_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> $past(ras_age) >= A_RAS);

  assert_cas_precharge_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) && $past(state) == ST_CASHI |-> hi_age > A_CP);

  assert_cas_high_at_ras_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> dram_cas_n && $past(dram_cas_n));

  assert_ras_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> ras_age <= A_RASP);

  assert_cas_inside_ras_R9: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n && !req_ready);

endmodule

// File: tb/dram_page_ctrl_bench.sv
module dram_page_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CYC      = 8;
  localparam int RASP_NS  = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [0:0]  req_wdata = '0;
  logic        req_burst = 1'b0;
  logic        rsp_valid;
  logic [0:0]  rsp_rdata;
  logic [9:0]  dram_a;
  logic        ras_n, cas_n, we_n;
  logic [0:0]  dram_di;
  logic [0:0]  dram_do = '0;

  always #(CYC/2) clk = ~clk;

  dram_page_ctrl #(.CLK_NS(CYC), .T_RASP_MAX_NS(RASP_NS)) u_dram_page_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_burst(req_burst),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_a(dram_a), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_di(dram_di), .dram_do(dram_do)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- memory model with nanosecond timing checks ----------------
  bit       mem [int];
  realtime  t_rf, t_rr, t_cf, t_cr;
  bit       seen_rf = 0, seen_rr = 0, seen_cr = 0;
  int       ras_falls = 0;
  int       cas_in_row = 0;
  int       gen = 0;
  logic [9:0] cur_row;
  int       log_q[$];

  always @(negedge ras_n) begin
    if (seen_rr) begin
      chk(($realtime - t_rr) >= 40.0, "R5 RAS precharge ns", longint'($realtime - t_rr), 40);
      chk(($realtime - t_rf) >= 110.0, "R5 RAS cycle ns", longint'($realtime - t_rf), 110);
    end
    t_rf = $realtime; seen_rf = 1; ras_falls++; cas_in_row = 0;
    #1 cur_row = dram_a;
    #10 chk(dram_a == cur_row, "R2 row address hold", dram_a, cur_row);
  end

  always @(posedge ras_n) begin
    if (seen_rf) begin
      chk(($realtime - t_rf) >= 60.0, "R5 RAS low min ns", longint'($realtime - t_rf), 60);
      chk(($realtime - t_rf) <= RASP_NS, "R8 RAS low ceiling ns", longint'($realtime - t_rf), RASP_NS);
      t_rr = $realtime; seen_rr = 1;
    end
  end

  always @(posedge cas_n) begin
    if (seen_rf) begin t_cr = $realtime; seen_cr = 1; end
  end

  always @(negedge cas_n) begin
    int a;
    bit v, d;
    realtime dv;
    gen++;
    if (cas_in_row == 0)
      chk(($realtime - t_rf) >= 20.0, "R2 RAS-to-CAS ns", longint'($realtime - t_rf), 20);
    else begin
      chk(($realtime - t_cr) >= 10.0, "R6 CAS precharge ns", longint'($realtime - t_cr), 10);
      chk(($realtime - t_cf) >= 40.0, "R6 page cycle ns", longint'($realtime - t_cf), 40);
    end
    cas_in_row++;
    t_cf = $realtime;
    #1;
    chk(req_ready == 1'b0, "R9 ready low during CAS", req_ready, 0);
    a = int'({cur_row, dram_a});
    log_q.push_back(a);
    if (!we_n) begin
      d = dram_di[0];
      mem[a] = d;
      #14 chk(dram_di[0] == d && !we_n && !cas_n, "R3 write data/WE hold", dram_di[0], d);
    end else begin
      v = mem.exists(a) ? mem[a] : 1'b0;
      dram_do[0] = ~v;
      dv = 30.0;
      if (t_rf + 60.0 - t_cf > dv) dv = t_rf + 60.0 - t_cf;
      dv = dv + 0.5 - 1.0;
      fork
        automatic int g = gen;
        automatic bit vv = v;
        automatic realtime dd = dv;
        begin
          #(dd);
          if (g == gen) dram_do[0] = vv;
        end
      join_none
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic wr; logic [19:0] addr; logic d; } exp_t;
  exp_t exp_q[$];
  bit   mirror [int];
  int   n_req = 0, n_rsp = 0;

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0) chk(0, "R9 response without request", 1, 0);
      else begin
        exp_t e;
        int la;
        e = exp_q.pop_front();
        la = (log_q.size() != 0) ? log_q.pop_front() : -1;
        chk(la == int'(e.addr), "R1 row/column on pins", la, e.addr);
        if (e.wr) chk(rsp_rdata[0] == 1'b0, "R3 write completion data", rsp_rdata, 0);
        else      chk(rsp_rdata[0] == e.d, "R4 read data", rsp_rdata, e.d);
      end
    end
  end

  task automatic do_req(input logic [19:0] a, input bit wr, input bit d, input bit keep);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata[0] = d; req_burst = keep;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    e.wr = wr; e.addr = a;
    if (wr) begin mirror[int'(a)] = d; e.d = 1'b0; end
    else e.d = mirror.exists(int'(a)) ? mirror[int'(a)] : 1'b0;
    exp_q.push_back(e);
    n_req++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CYC * 150000);
    n_bad++;
    $display("FAIL watchdog expired (R9 progress) actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int rf0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(ras_n == 1'b1, "R10 RAS idle", ras_n, 1);
    chk(cas_n == 1'b1, "R10 CAS idle", cas_n, 1);
    chk(we_n == 1'b1, "R10 WE idle", we_n, 1);
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10 no completion after reset", rsp_valid, 0);

    // single cycles: R1 R3 R4 R5
    do_req(20'h12345, 1, 1, 0);
    do_req(20'h12345, 0, 0, 0);
    do_req(20'hABCDE, 1, 0, 0);
    do_req(20'hABCDE, 0, 0, 0);
    do_req(20'h00777, 0, 0, 0);
    drain();

    // page burst on one row: R6
    rf0 = ras_falls;
    for (int i = 0; i < 8; i++) do_req({10'h2A5, 10'(i)}, 1, i[0] ^ i[2], 1);
    for (int i = 0; i < 8; i++) do_req({10'h2A5, 10'(i)}, 0, 0, (i != 7));
    drain();
    chk(ras_falls - rf0 == 1, "R6 one row activation for a burst", ras_falls - rf0, 1);

    // page miss: R7
    rf0 = ras_falls;
    do_req({10'h011, 10'h005}, 1, 1, 1);
    do_req({10'h022, 10'h005}, 0, 0, 1);
    do_req({10'h022, 10'h006}, 0, 0, 1);
    do_req({10'h011, 10'h005}, 0, 0, 0);
    drain();
    chk(ras_falls - rf0 == 3, "R7 row reopened on miss", ras_falls - rf0, 3);

    // idle open page is closed: R8
    do_req({10'h033, 10'h001}, 0, 0, 1);
    repeat (500) @(negedge clk);
    chk(ras_n == 1'b1, "R8 idle page closed", ras_n, 1);

    // long burst crosses the ceiling: R8
    rf0 = ras_falls;
    for (int i = 0; i < 60; i++) do_req({10'h2A5, 10'(i % 8)}, 0, 0, (i != 59));
    drain();
    chk(ras_falls - rf0 >= 2, "R8 forced close in long burst", ras_falls - rf0, 2);

    // mixed traffic over three rows
    for (int i = 0; i < 60; i++) begin
      logic [9:0] r;
      r = 10'(100 + ($urandom % 3));
      do_req({r, 10'($urandom % 16)}, bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 4 != 0));
    end
    do_req(20'h00000, 0, 0, 0);
    drain();
    chk(n_req == n_rsp, "R9 one completion per request", n_rsp, n_req);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule